// File: doc/BRIEF.md
# Parallel ADC Acquisition Controller

This block runs one acquisition frame on a six-channel simultaneous-sampling ADC with a 16-bit parallel bus. It divides the system clock into a square conversion clock. After reset it holds the converter's reset line high for a settling interval and then pulses it low once. This parks the converter's internal read pointer on the first channel.

A start request in the idle state drops all three sample-hold lines together. The lines stay low for a bounded number of conversion clocks. The controller then waits for three end-of-conversion pulses, one per channel pair, and issues six read strobes. Each strobe returns one result on a single-cycle valid output together with its channel index. The sixth result carries a frame-done flag, and the controller goes back to idle.

Reads use the converter's pointer-based mode, so no per-channel address is driven. A parameter selects which of the two pointer modes is coded on the address pins. Command writes are never issued.

Top module: `adc_frame_ctrl`

## Requirements
- R1: `adc_clk` is a free-running square wave that is high for exactly CLK_HALF system clocks and then low for exactly CLK_HALF system clocks.
- R2: After reset, `adc_rst_n` stays high for at least PWRUP_WAIT cycles. It then goes low exactly once, for RST_LOW cycles. A start request that arrives before this sequence ends is ignored.
- R3: `adc_hold_a_n`, `adc_hold_b_n` and `adc_hold_c_n` always carry the same value. They go low only in response to a start request accepted in the idle state.
- R4: The hold lines stay low for at least one complete conversion-clock period (2×CLK_HALF system clocks). They are high again before the 20th rising edge of `adc_clk` that follows their fall.
- R5: No read strobe is issued before three falling edges have appeared on `adc_eoc_n` since the hold. A low pulse that lasts only half a conversion clock still counts as an edge.
- R6: Each frame gives exactly six results, with `out_chan` taking the values 0,1,2,3,4,5 in order (channel pairs A, B, C, two channels each). Each `out_data` equals the value on `adc_data` at the system-clock edge where `adc_rd_n` returns high. `out_valid` is high for that one cycle.
- R7: `adc_cs_n` is low whenever `adc_rd_n` is low. `adc_wr_n` is always high. While `adc_cs_n` is low, `adc_addr` is 6 (cycle mode) by default, or 7 (FIFO mode) when FIFO_MODE is set.
- R8: Each read strobe keeps `adc_rd_n` low for exactly RD_LOW cycles. Between two reads of one frame it is high for exactly RD_HIGH cycles. Both counts are raised to 2 if set lower.
- R9: `frame_done` is high for one cycle only, together with the valid result on channel 5. A start request during a frame is ignored, and a new frame needs a new start in idle.
- R10: During reset, `adc_rd_n`, `adc_cs_n`, `adc_wr_n`, `adc_rst_n` and all hold lines are high, and `out_valid` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one acquisition frame (accepted in idle) |
| adc_eoc_n | input | 1 | End-of-conversion from the ADC, active low, asynchronous |
| adc_data | input | 16 | ADC parallel data bus |
| adc_clk | output | 1 | Divided conversion clock |
| adc_rst_n | output | 1 | ADC reset, active low |
| adc_hold_a_n | output | 1 | Sample-hold for channel pair A, active low |
| adc_hold_b_n | output | 1 | Sample-hold for channel pair B, active low |
| adc_hold_c_n | output | 1 | Sample-hold for channel pair C, active low |
| adc_cs_n | output | 1 | ADC chip select, active low |
| adc_rd_n | output | 1 | ADC read strobe, active low |
| adc_wr_n | output | 1 | ADC write strobe, held inactive |
| adc_addr | output | 3 | ADC address pins, pointer-mode code |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Captured conversion result |
| out_chan | output | 3 | Channel index of the result, 0..5 |
| frame_done | output | 1 | Marks the last result of a frame |

## Verification
The bench drives EOC as pulses only half a conversion clock long, three in quick succession. A controller that samples EOC by level, or that loses an edge in the synchroniser, would hang waiting or read a frame too early.

The bench model changes the bus value only on the falling edge of the strobe. A design that captured on the falling edge instead of at the rising edge would return the previous channel's word.

Start requests are pulsed during the power-up sequence and again in the middle of a conversion. A design that let them through would produce an extra hold pulse, and the bench counts hold pulses.

The data patterns include all-ones and walking bits. The bench also checks the exact order of the six channel indices and that frame-done appears only on the sixth.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    localparam int SMP_W     = 16;
    localparam int NUM_RES   = 6;
    localparam int NUM_PAIRS = 3;
    localparam int CH_W      = $clog2(NUM_RES);
    localparam int ADR_W     = 3;
    localparam int CONV_CCLKS = 20;

    localparam logic [ADR_W-1:0] ADR_PTR_CYCLE = 3'd6;
    localparam logic [ADR_W-1:0] ADR_PTR_FIFO  = 3'd7;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_RSTLO,
        ST_IDLE,
        ST_HOLD,
        ST_WAITEOC,
        ST_RDLO,
        ST_RDHI
    } ctl_state_t;

    typedef struct packed {
        logic            valid;
        logic            last;
        logic [CH_W-1:0] chan;
        logic [SMP_W-1:0] data;
    } adc_result_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int clamp(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/adc_conv_clk_div.sv
module adc_conv_clk_div #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    output logic cclk,
    output logic rise_tick
);
    localparam int HALF_EFF = (HALF < 1) ? 1 : HALF;
    localparam int CW = $clog2(HALF_EFF + 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(HALF_EFF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            cclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            cclk <= ~cclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // asserted in the cycle before cclk goes high
    assign rise_tick = wrap && !cclk;
endmodule

// File: rtl/adc_eoc_edge.sv
module adc_eoc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic eoc_n_async,
    output logic fall
);
    localparam int SW = (SYNC_STAGES < 2) ? 3 : SYNC_STAGES + 1;

    logic [SW-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[SW-2:0], eoc_n_async};
    end

    // last stage is the history bit used for edge detection
    assign fall = pipe[SW-1] && !pipe[SW-2];
endmodule

// File: rtl/adc_result_capture.sv
module adc_result_capture
    import adc_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [CH_W-1:0]  chan,
    input  logic [SMP_W-1:0] bus,
    output adc_result_t      res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.valid <= take;
            res.last  <= take && (chan == CH_W'(NUM_RES - 1));
            if (take) begin
                res.chan <= chan;
                res.data <= bus;
            end
        end
    end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_frame_pkg::*;
#(
    parameter int CLK_HALF   = 4,
    parameter int PWRUP_WAIT = 16,
    parameter int RST_LOW    = 8,
    parameter int HOLD_CCLKS = 1,
    parameter int RD_LOW     = 3,
    parameter int RD_HIGH    = 2,
    parameter bit FIFO_MODE  = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adc_eoc_n,
    input  logic [SMP_W-1:0] adc_data,
    output logic             adc_clk,
    output logic             adc_rst_n,
    output logic             adc_hold_a_n,
    output logic             adc_hold_b_n,
    output logic             adc_hold_c_n,
    output logic             adc_cs_n,
    output logic             adc_rd_n,
    output logic             adc_wr_n,
    output logic [ADR_W-1:0] adc_addr,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_data,
    output logic [CH_W-1:0]  out_chan,
    output logic             frame_done
);
    localparam int PW_EFF   = (PWRUP_WAIT < 1) ? 1 : PWRUP_WAIT;
    localparam int RL_EFF   = (RST_LOW < 1) ? 1 : RST_LOW;
    localparam int RDL_EFF  = (RD_LOW < 2) ? 2 : RD_LOW;
    localparam int RDH_EFF  = (RD_HIGH < 2) ? 2 : RD_HIGH;
    localparam int HOLD_EFF = clamp(HOLD_CCLKS, 1, CONV_CCLKS - 2);
    localparam int TMAX     = imax(imax(PW_EFF, RL_EFF), imax(RDL_EFF, RDH_EFF));
    localparam int TW       = $clog2(TMAX + 1);
    localparam int HW       = $clog2(HOLD_EFF + 1);
    localparam int EW       = $clog2(NUM_PAIRS + 1);

    ctl_state_t      state;
    logic [TW-1:0]   tmr;
    logic [HW-1:0]   rise_cnt;
    logic [EW-1:0]   eoc_cnt;
    logic [CH_W-1:0] chan;
    logic            cclk_rise;
    logic            eoc_fall;
    logic            take;
    logic [NUM_PAIRS-1:0] hold_n;
    adc_result_t     res;

    adc_conv_clk_div #(.HALF(CLK_HALF)) u_div (
        .clk      (clk),
        .rst      (rst),
        .cclk     (adc_clk),
        .rise_tick(cclk_rise)
    );

    adc_eoc_edge #(.SYNC_STAGES(2)) u_eoc (
        .clk        (clk),
        .rst        (rst),
        .eoc_n_async(adc_eoc_n),
        .fall       (eoc_fall)
    );

    assign take = (state == ST_RDLO) && (tmr == TW'(RDL_EFF - 1));

    adc_result_capture u_cap (
        .clk (clk),
        .rst (rst),
        .take(take),
        .chan(chan),
        .bus (adc_data),
        .res (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_PWRUP;
            tmr      <= '0;
            rise_cnt <= '0;
            eoc_cnt  <= '0;
            chan     <= '0;
        end else begin
            if ((state == ST_HOLD || state == ST_WAITEOC) && eoc_fall
                && eoc_cnt != EW'(NUM_PAIRS))
                eoc_cnt <= eoc_cnt + 1'b1;
            unique case (state)
                ST_PWRUP: begin
                    if (tmr == TW'(PW_EFF - 1)) begin
                        tmr   <= '0;
                        state <= ST_RSTLO;
                    end else tmr <= tmr + 1'b1;
                end
                ST_RSTLO: begin
                    if (tmr == TW'(RL_EFF - 1)) begin
                        tmr   <= '0;
                        state <= ST_IDLE;
                    end else tmr <= tmr + 1'b1;
                end
                ST_IDLE: begin
                    if (start) begin
                        rise_cnt <= '0;
                        eoc_cnt  <= '0;
                        chan     <= '0;
                        state    <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    // one extra rise guarantees a whole period from any phase
                    if (cclk_rise) begin
                        if (rise_cnt == HW'(HOLD_EFF)) state <= ST_WAITEOC;
                        else rise_cnt <= rise_cnt + 1'b1;
                    end
                end
                ST_WAITEOC: begin
                    if (eoc_cnt == EW'(NUM_PAIRS)) begin
                        tmr   <= '0;
                        state <= ST_RDLO;
                    end
                end
                ST_RDLO: begin
                    if (take) begin
                        tmr   <= '0;
                        state <= ST_RDHI;
                    end else tmr <= tmr + 1'b1;
                end
                ST_RDHI: begin
                    if (tmr == TW'(RDH_EFF - 1)) begin
                        tmr <= '0;
                        if (chan == CH_W'(NUM_RES - 1)) begin
                            state <= ST_IDLE;
                        end else begin
                            chan  <= chan + 1'b1;
                            state <= ST_RDLO;
                        end
                    end else tmr <= tmr + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_hold
        assign hold_n[g] = (state != ST_HOLD);
    end

    assign adc_hold_a_n = hold_n[0];
    assign adc_hold_b_n = hold_n[1];
    assign adc_hold_c_n = hold_n[2];
    assign adc_rst_n    = (state != ST_RSTLO);
    assign adc_rd_n     = (state != ST_RDLO);
    assign adc_cs_n     = !(state == ST_RDLO || state == ST_RDHI);
    assign adc_wr_n     = 1'b1;

    if (FIFO_MODE) begin : g_fifo
        assign adc_addr = ADR_PTR_FIFO;
    end else begin : g_cycle
        assign adc_addr = ADR_PTR_CYCLE;
    end

    assign out_valid  = res.valid;
    assign out_data   = res.data;
    assign out_chan   = res.chan;
    assign frame_done = res.last;
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk
    import adc_frame_pkg::*;
#(
    parameter bit FIFO_MODE = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             adc_rst_n,
    input logic             adc_hold_a_n,
    input logic             adc_hold_b_n,
    input logic             adc_hold_c_n,
    input logic             adc_cs_n,
    input logic             adc_rd_n,
    input logic             adc_wr_n,
    input logic [ADR_W-1:0] adc_addr,
    input logic             out_valid,
    input logic [CH_W-1:0]  out_chan,
    input logic             frame_done
);
    localparam logic [ADR_W-1:0] CODE = FIFO_MODE ? ADR_PTR_FIFO : ADR_PTR_CYCLE;

    assert_holds_together_R3: assert property (@(posedge clk) disable iff (rst)
        (adc_hold_a_n == adc_hold_b_n) && (adc_hold_b_n == adc_hold_c_n));

    assert_no_read_in_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !adc_hold_a_n |-> adc_rd_n);

    assert_valid_on_rd_rise_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $rose(adc_rd_n));

    assert_chan_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_chan < CH_W'(NUM_RES)));

    assert_cs_covers_rd_R7: assert property (@(posedge clk) disable iff (rst)
        !adc_rd_n |-> !adc_cs_n);

    assert_addr_code_R7: assert property (@(posedge clk) disable iff (rst)
        !adc_cs_n |-> (adc_addr == CODE && adc_wr_n));

    assert_done_last_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (out_valid && out_chan == CH_W'(NUM_RES - 1)));

    assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
        !adc_rst_n |-> (adc_hold_a_n && adc_cs_n));
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(.FIFO_MODE(FIFO_MODE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .adc_rst_n   (adc_rst_n),
    .adc_hold_a_n(adc_hold_a_n),
    .adc_hold_b_n(adc_hold_b_n),
    .adc_hold_c_n(adc_hold_c_n),
    .adc_cs_n    (adc_cs_n),
    .adc_rd_n    (adc_rd_n),
    .adc_wr_n    (adc_wr_n),
    .adc_addr    (adc_addr),
    .out_valid   (out_valid),
    .out_chan    (out_chan),
    .frame_done  (frame_done)
);

// File: tb/adc_frame_ctrl_test.sv
`timescale 1ns/1ps
module adc_frame_ctrl_test;
    localparam int HALF = 4, PWW = 16, RSL = 8, RDL = 3, RDH = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        adc_eoc_n = 1'b1;
    logic [15:0] adc_data = 16'h0;
    logic        adc_clk, adc_rst_n, adc_hold_a_n, adc_hold_b_n, adc_hold_c_n;
    logic        adc_cs_n, adc_rd_n, adc_wr_n;
    logic [2:0]  adc_addr;
    logic        out_valid;
    logic [15:0] out_data;
    logic [2:0]  out_chan;
    logic        frame_done;

    int n_chk = 0, n_fail = 0;
    int holds_fell = 0;       // hold pulses seen
    int eoc_sent = 0;         // EOC falls in current frame
    int ptr = 0;              // ADC model read pointer
    int cur_frame = -1;
    int vcount = 0;           // results seen in current frame
    int dones = 0;
    int cyc = 0;

    always #2 clk = ~clk;     // 250 MHz

    adc_frame_ctrl #(.CLK_HALF(HALF), .PWRUP_WAIT(PWW), .RST_LOW(RSL),
                     .HOLD_CCLKS(1), .RD_LOW(RDL), .RD_HIGH(RDH), .FIFO_MODE(1'b0)) uut (
        .clk(clk), .rst(rst), .start(start), .adc_eoc_n(adc_eoc_n), .adc_data(adc_data),
        .adc_clk(adc_clk), .adc_rst_n(adc_rst_n), .adc_hold_a_n(adc_hold_a_n),
        .adc_hold_b_n(adc_hold_b_n), .adc_hold_c_n(adc_hold_c_n), .adc_cs_n(adc_cs_n),
        .adc_rd_n(adc_rd_n), .adc_wr_n(adc_wr_n), .adc_addr(adc_addr),
        .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan),
        .frame_done(frame_done));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] word(input int f, input int c);
        if (f == 0)      return 16'h1230 + 16'(c);
        else if (f == 1) return 16'hFFFF - 16'(c);
        else             return 16'h5A5A ^ (16'h0001 << (c * 3));
    endfunction

    // ---------------- ADC behavioural model ----------------
    always @(negedge adc_rst_n) ptr = 0;

    always @(negedge adc_rd_n) begin
        #1;
        if (!adc_cs_n) begin
            adc_data = word(cur_frame, ptr);
            ptr = (ptr + 1) % 6;
        end
    end

    always begin
        @(negedge adc_hold_a_n);
        holds_fell++;
        cur_frame++;
        eoc_sent = 0;
        vcount = 0;
        for (int i = 0; i < 20; i++) @(posedge adc_clk);
        #0.5;
        chk(adc_hold_a_n && adc_hold_b_n && adc_hold_c_n, "R4", "hold released before 20th conv clock",
            {adc_hold_a_n, adc_hold_b_n, adc_hold_c_n}, 3'b111);
        for (int k = 0; k < 3; k++) begin
            adc_eoc_n = 1'b0;
            eoc_sent++;
            @(negedge adc_clk);
            adc_eoc_n = 1'b1;
            @(posedge adc_clk);
        end
    end

    // ---------------- per-clock reference checks ----------------
    logic p_clk = 1'b0, p_rstn = 1'b1, p_rd = 1'b1, p_hold = 1'b1;
    int   run_clk = 0, clk_runs = 0, run_rstn = 0, rst_lows = 0, high_before = 0;
    int   run_rd = 0, run_hold = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            // R1 square wave
            if (adc_clk != p_clk) begin
                if (clk_runs > 0)
                    chk(run_clk == HALF, "R1", "conversion clock half period", run_clk, HALF);
                clk_runs++;
                run_clk = 1;
            end else run_clk++;
            // R2 reset pulse
            if (adc_rst_n != p_rstn) begin
                if (!adc_rst_n) begin
                    rst_lows++;
                    chk(rst_lows == 1, "R2", "single reset pulse", rst_lows, 1);
                    chk(run_rstn >= PWW, "R2", "reset high before pulse", run_rstn, PWW);
                end else
                    chk(run_rstn == RSL, "R2", "reset low width", run_rstn, RSL);
                run_rstn = 1;
            end else run_rstn++;
            // R3 hold lines together
            chk(adc_hold_a_n == adc_hold_b_n && adc_hold_b_n == adc_hold_c_n, "R3",
                "holds equal", {adc_hold_a_n, adc_hold_b_n, adc_hold_c_n}, {3{adc_hold_a_n}});
            // R4 hold width
            if (adc_hold_a_n != p_hold) begin
                if (adc_hold_a_n)
                    chk(run_hold >= 2 * HALF, "R4", "hold low width", run_hold, 2 * HALF);
                run_hold = 1;
            end else run_hold++;
            // R5, R8 strobe timing
            if (adc_rd_n != p_rd) begin
                if (!adc_rd_n) begin
                    chk(eoc_sent == 3, "R5", "EOC pulses before read", eoc_sent, 3);
                    if (vcount > 0)
                        chk(run_rd == RDH, "R8", "RD high between reads", run_rd, RDH);
                end else
                    chk(run_rd == RDL, "R8", "RD low width", run_rd, RDL);
                run_rd = 1;
            end else run_rd++;
            // R7 bus control
            if (!adc_rd_n) chk(!adc_cs_n, "R7", "CS low during RD", adc_cs_n, 0);
            if (!adc_cs_n) chk(adc_addr == 3'd6, "R7", "cycle mode address", adc_addr, 6);
            chk(adc_wr_n, "R7", "WR inactive", adc_wr_n, 1);
            // R6, R9 results
            if (out_valid) begin
                chk(out_chan == 3'(vcount), "R6", "channel order", out_chan, vcount);
                chk(out_data == word(cur_frame, vcount), "R6", "captured data",
                    out_data, word(cur_frame, vcount));
                chk(frame_done == (vcount == 5), "R9", "frame_done on last", frame_done, vcount == 5);
                vcount++;
            end else
                chk(!frame_done, "R9", "frame_done without valid", frame_done, 0);
            if (frame_done) dones++;
        end
        p_clk = adc_clk; p_rstn = adc_rst_n; p_rd = adc_rd_n; p_hold = adc_hold_a_n;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(input int target);
        while (dones < target) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(adc_rd_n && adc_cs_n && adc_wr_n && adc_rst_n, "R10", "strobes idle in reset",
            {adc_rd_n, adc_cs_n, adc_wr_n, adc_rst_n}, 4'hF);
        chk(adc_hold_a_n && adc_hold_b_n && adc_hold_c_n, "R10", "holds idle in reset",
            {adc_hold_a_n, adc_hold_b_n, adc_hold_c_n}, 3'b111);
        chk(!out_valid && !frame_done, "R10", "outputs quiet in reset", {out_valid, frame_done}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        pulse_start();                       // during power-up: ignored
        while (rst_lows == 0 || !adc_rst_n) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(holds_fell == 0, "R2", "start during power-up ignored", holds_fell, 0);

        for (int f = 0; f < 3; f++) begin
            pulse_start();
            if (f == 1) begin
                repeat (40) @(negedge clk);
                pulse_start();               // mid-conversion: ignored
            end
            wait_done(f + 1);
            repeat (60) @(negedge clk);
            chk(holds_fell == f + 1, "R9", "one hold per accepted start", holds_fell, f + 1);
            chk(vcount == 6, "R6", "six results per frame", vcount, 6);
            chk(adc_cs_n && adc_rd_n, "R9", "idle after frame", {adc_cs_n, adc_rd_n}, 2'b11);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule